// File: doc/BRIEF.md
# Parallel ADC Read Controller

This block runs a parallel-output analog-to-digital converter from the host side. While `enable_i` is high it sends a start pulse to the converter. It then watches the converter's shared status line until that line reports completion. Next it drives chip-select and read low together for a fixed number of cycles and captures the 14-bit result from the data bus. It then holds off the next start until a quiet interval has passed. This lets the converter's bus settle before the next conversion begins.

Two signalling conventions are supported, selected by `mode_level_i`.

- **Pulse convention** (`mode_level_i` = 0): the start output rests high and dips low. Completion is a single-cycle low blip on the status line.
- **Level convention** (`mode_level_i` = 1): the start output rests low and rises. The status line acts as a busy flag. It goes high after the start, falls low at completion and stays low until the next start.

Each captured word is handed to the consumer through a valid/ready pair. The controller starts no new conversion while a word is still waiting to be taken. A timeout flag reports a converter that never signals completion.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, with `mode_level_i` low: `start_o`, `cs_no` and `rd_no` are high, and `sample_valid_o` and `timeout_o` are low.
- R2: In the pulse convention (`mode_level_i` = 0), `start_o` rests high. It is driven low for exactly START_W (default 2) consecutive cycles per conversion.
- R3: In the level convention (`mode_level_i` = 1), `start_o` rests low. It is driven high for exactly START_W consecutive cycles per conversion.
- R4: In the pulse convention, a low of one clock on `status_i` after the start ends the wait. The word on `data_i` is then read.
- R5: In the level convention, completion is a low on `status_i` that follows a high seen after the start. A low still left over from the previous conversion does not end the wait.
- R6: `cs_no` and `rd_no` fall together and stay low for exactly RD_CYCLES (default 3) cycles. `data_i` is captured on the last of those cycles.
- R7: After `rd_no` returns high, at least QUIET_CYCLES cycles pass before `start_o` leaves its resting level. By default QUIET_CYCLES is 8, which is 150 ns rounded up to whole cycles of a 20 ns clock.
- R8: Once `sample_valid_o` is high, it and `sample_o` hold steady until a cycle with `sample_ready_i` high. No start pulse is issued while the word is pending.
- R9: If completion is not seen within TIMEOUT_CYCLES (default 256) cycles after the start pulse ends, no read takes place. `timeout_o` rises START_W+TIMEOUT_CYCLES cycles after the start pulse began. It stays high until the next start pulse begins.
- R10: The convention is taken from `mode_level_i` only while the controller is idle. A change during a conversion leaves `start_o` at the latched resting level until the controller is idle again.
- R11: A low pulse on `status_i` while no conversion is in flight causes no read and no valid sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Host clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| enable_i | input | 1 | Allows conversions to be started back to back |
| mode_level_i | input | 1 | 0 = pulse convention, 1 = level (busy) convention |
| status_i | input | 1 | Converter completion/busy line, asynchronous |
| data_i | input | 14 | Converter parallel data bus |
| start_o | output | 1 | Conversion start line to the converter |
| cs_no | output | 1 | Chip-select, active low |
| rd_no | output | 1 | Read strobe, active low |
| sample_o | output | 14 | Captured conversion result |
| sample_valid_o | output | 1 | `sample_o` holds an unaccepted result |
| sample_ready_i | input | 1 | Consumer takes the result |
| timeout_o | output | 1 | Last conversion never reported completion |

## Verification
The hardest case to reach is a level-convention start in which the status line is still low from the previous conversion and rises only several cycles into the wait. A controller that mistakes the stale low for completion reads too early. To force this case, the bench's converter model has a programmable delay before it raises busy. Its data bus returns zero until the conversion has really ended, so an early read shows up as a wrong sample value. A second hard case is a convention change in the middle of a conversion. The bench flips `mode_level_i` while the controller waits for completion, and it watches the start line until the controller is idle again.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_START = 3'd1,
        ST_WAIT  = 3'd2,
        ST_READ  = 3'd3,
        ST_QUIET = 3'd4
    } ctrl_state_e;

    function automatic int unsigned max_of4(input int unsigned a, input int unsigned b,
                                            input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/adc_status_sync.sv
module adc_status_sync #(
    parameter int unsigned STAGES  = 2,
    parameter logic        RST_VAL = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic sync_o
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], async_i};
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) chain_q <= {STAGES{RST_VAL}};
        else         chain_q <= chain_d;
    end

    assign sync_o = chain_q[STAGES-1];
endmodule

// File: rtl/adc_done_detect.sv
module adc_done_detect (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic level_mode_i,
    input  logic arm_i,
    input  logic status_i,
    output logic done_o
);
    typedef struct packed {
        logic prev;
        logic seen_busy;
    } det_t;

    det_t det_d, det_q;

    always_comb begin
        det_d.prev      = status_i;
        // a high on the line during arming counts, so set wins over clear
        det_d.seen_busy = (arm_i ? 1'b0 : det_q.seen_busy) | status_i;
        if (level_mode_i) done_o = det_q.seen_busy & ~status_i;
        else              done_o = det_q.prev & ~status_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) det_q <= '{prev: 1'b1, seen_busy: 1'b0};
        else         det_q <= det_d;
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int unsigned DATA_W         = 14,
    parameter int unsigned START_W        = 2,
    parameter int unsigned RD_CYCLES      = 3,
    parameter int unsigned CLK_PERIOD_NS  = 20,
    parameter int unsigned QUIET_NS       = 150,
    parameter int unsigned TIMEOUT_CYCLES = 256,
    parameter int unsigned SYNC_STAGES    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              enable_i,
    input  logic              mode_level_i,
    input  logic              status_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              start_o,
    output logic              cs_no,
    output logic              rd_no,
    output logic [DATA_W-1:0] sample_o,
    output logic              sample_valid_o,
    input  logic              sample_ready_i,
    output logic              timeout_o
);
    localparam int unsigned QUIET_CYC = (QUIET_NS + CLK_PERIOD_NS - 1) / CLK_PERIOD_NS;
    localparam int unsigned MAX_CNT   = max_of4(START_W, RD_CYCLES, QUIET_CYC, TIMEOUT_CYCLES);
    localparam int unsigned CNT_W     = $clog2(MAX_CNT + 1);
    localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_W - 1);
    localparam logic [CNT_W-1:0] RD_LAST    = CNT_W'(RD_CYCLES - 1);
    localparam logic [CNT_W-1:0] QUIET_LAST = CNT_W'(QUIET_CYC - 1);
    localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TIMEOUT_CYCLES - 1);

    typedef struct packed {
        ctrl_state_e       st;
        logic [CNT_W-1:0]  cnt;
        logic              mode;
        logic [DATA_W-1:0] smp;
        logic              vld;
        logic              tmo;
    } ctrl_t;

    ctrl_t ctl_d, ctl_q;
    logic  status_sync;
    logic  conv_done;

    adc_status_sync #(
        .STAGES  (SYNC_STAGES),
        .RST_VAL (1'b1)
    ) status_sync_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .async_i (status_i),
        .sync_o  (status_sync)
    );

    adc_done_detect done_det_i (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .level_mode_i (ctl_q.mode),
        .arm_i        (ctl_q.st == ST_START),
        .status_i     (status_sync),
        .done_o       (conv_done)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (ctl_q.vld && sample_ready_i) ctl_d.vld = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                ctl_d.mode = mode_level_i;
                if (enable_i && !ctl_q.vld) begin
                    ctl_d.st  = ST_START;
                    ctl_d.cnt = '0;
                    ctl_d.tmo = 1'b0;
                end
            end
            ST_START: begin
                if (ctl_q.cnt == START_LAST) begin
                    ctl_d.st  = ST_WAIT;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (conv_done) begin
                    ctl_d.st  = ST_READ;
                    ctl_d.cnt = '0;
                end else if (ctl_q.cnt == TMO_LAST) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.cnt = '0;
                    ctl_d.tmo = 1'b1;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_READ: begin
                if (ctl_q.cnt == RD_LAST) begin
                    ctl_d.smp = data_i;
                    ctl_d.vld = 1'b1;
                    ctl_d.st  = ST_QUIET;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            ST_QUIET: begin
                if (ctl_q.cnt == QUIET_LAST) begin
                    ctl_d.st  = ST_IDLE;
                    ctl_d.cnt = '0;
                end else begin
                    ctl_d.cnt = ctl_q.cnt + 1'b1;
                end
            end
            default: begin
                ctl_d.st  = ST_IDLE;
                ctl_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ctl_q <= '{st: ST_IDLE, cnt: '0, mode: 1'b0, smp: '0, vld: 1'b0, tmo: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign start_o        = ctl_q.mode ? (ctl_q.st == ST_START) : (ctl_q.st != ST_START);
    assign cs_no          = (ctl_q.st != ST_READ);
    assign rd_no          = (ctl_q.st != ST_READ);
    assign sample_o       = ctl_q.smp;
    assign sample_valid_o = ctl_q.vld;
    assign timeout_o      = ctl_q.tmo;

    // pending word is held steady until taken
    assert_valid_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_valid_o && !sample_ready_i) |=> (sample_valid_o && $stable(sample_o)));

    // no start pulse while a word waits
    assert_no_start_pending_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_IDLE && sample_valid_o) |=> (ctl_q.st != ST_START));

    // a read is always followed by the quiet window
    assert_read_to_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_READ) |=> (ctl_q.st == ST_READ || ctl_q.st == ST_QUIET));

    assert_quiet_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st == ST_QUIET) |-> (ctl_q.cnt <= QUIET_LAST));

    // timeout comes out of the wait without any read
    assert_timeout_no_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(timeout_o) |-> (cs_no && rd_no && $past(ctl_q.st) == ST_WAIT));

    // convention latched outside idle
    assert_mode_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ctl_q.st != ST_IDLE) |=> (ctl_q.st == ST_IDLE || $stable(ctl_q.mode)));
endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
    localparam int START_EXP   = 2;
    localparam int RD_EXP      = 3;
    localparam int QUIET_EXP   = 8;   // 150 ns at 20 ns period, rounded up
    localparam int TMO_EXP     = 256;
    localparam int CONV_LAT    = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        mode_level = 1'b0;
    logic        status = 1'b1;
    logic [13:0] data;
    logic        ready = 1'b0;
    logic        start_o, cs_no, rd_no, sample_valid_o, timeout_o;
    logic [13:0] sample_o;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    adc_rd_ctrl dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .enable_i       (enable),
        .mode_level_i   (mode_level),
        .status_i       (status),
        .data_i         (data),
        .start_o        (start_o),
        .cs_no          (cs_no),
        .rd_no          (rd_no),
        .sample_o       (sample_o),
        .sample_valid_o (sample_valid_o),
        .sample_ready_i (ready),
        .timeout_o      (timeout_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // ---------------- converter model ----------------
    bit          m_level = 0;
    bit          resp_en = 1;
    bit          inj_pulse = 0;
    bit          eoc_restore = 0;
    bit          conv_done = 0;
    bit          prev_start = 1;
    int          conv_cnt = 0;
    int          late_busy = 0;
    int          late_cnt = 0;
    int          res_n = 0;
    logic [13:0] last_result = '0;

    assign data = (!cs_no && !rd_no && conv_done) ? last_result : 14'h0;

    always @(negedge clk) begin
        if (!rst_n) begin
            status = 1'b1; conv_cnt = 0; late_cnt = 0; eoc_restore = 0; prev_start = 1;
        end else begin
            if (eoc_restore) begin status = 1'b1; eoc_restore = 0; end
            if (inj_pulse) begin status = 1'b0; eoc_restore = 1; inj_pulse = 0; end
            if (late_cnt > 0) begin
                late_cnt--;
                if (late_cnt == 0) status = 1'b1;
            end
            if (conv_cnt > 0) begin
                conv_cnt--;
                if (conv_cnt == 0 && resp_en) begin
                    res_n++;
                    last_result = 14'((res_n * 1237 + 91) & 16'h3FFF);
                    conv_done = 1;
                    status = 1'b0;
                    if (!m_level) eoc_restore = 1;
                end
            end
            if (start_o && !prev_start) begin
                conv_cnt = CONV_LAT;
                conv_done = 0;
                if (m_level) begin
                    if (late_busy == 0) status = 1'b1;
                    else late_cnt = late_busy;
                end
            end
            prev_start = start_o;
        end
    end

    // ---------------- port monitor ----------------
    int rd_run = 0;
    int gap = 0;
    bit rd_seen = 0;
    bit prev_act = 0;
    bit mon_mute = 0;
    int start_cnt = 0;
    int cs_fall_cnt = 0;
    bit prev_cs = 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_cs && !cs_no) cs_fall_cnt++;
            prev_cs = cs_no;
            // R6: read strobe length, both strobes together
            if (!rd_no || !cs_no) begin
                rd_run++;
                if (rd_no != cs_no) chk(0, "R6", "cs_no/rd_no differ", int'(cs_no), int'(rd_no));
            end else if (rd_run > 0) begin
                chk(rd_run == RD_EXP, "R6", "read strobe length", rd_run, RD_EXP);
                rd_run = 0; gap = 0; rd_seen = 1;
            end
            if (!mon_mute && (start_o == m_level)) begin
                if (!prev_act) begin
                    start_cnt++;
                    // R7: quiet gap between read release and next start
                    if (rd_seen) chk(gap >= QUIET_EXP, "R7", "quiet gap cycles", gap, QUIET_EXP);
                    rd_seen = 0;
                end
                prev_act = 1;
            end else begin
                prev_act = 0;
            end
            if (rd_no) gap++;
        end
    end

    // ---------------- helpers ----------------
    task automatic wait_valid(input string req, output bit got);
        got = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (sample_valid_o) begin got = 1; break; end
        end
        if (!got) chk(0, req, "sample never valid", 0, 1);
    endtask

    task automatic accept();
        ready = 1'b1;
        @(negedge clk);
        ready = 1'b0;
    endtask

    task automatic start_len(input string req, output int len);
        bit seen;
        seen = 0;
        len = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (start_o == m_level) begin seen = 1; break; end
        end
        if (!seen) begin
            chk(0, req, "start pulse never seen", 0, 1);
        end else begin
            len = 1;
            for (int i = 0; i < 50; i++) begin
                @(negedge clk);
                if (start_o == m_level) len++;
                else break;
            end
        end
    endtask

    task automatic set_mode(input bit lvl);
        mon_mute = 1;
        mode_level = lvl;
        m_level = lvl;
        repeat (4) @(negedge clk);
        mon_mute = 0;
    endtask

    task automatic run_convs(input string req_start, input string req_done, input int n);
        int len;
        bit got;
        enable = 1'b1;
        for (int k = 0; k < n; k++) begin
            start_len(req_start, len);
            chk(len == START_EXP, req_start, "start pulse width", len, START_EXP);
            wait_valid(req_done, got);
            if (got) chk(sample_o == last_result && sample_o != 0, req_done, "captured sample",
                         int'(sample_o), int'(last_result));
            if (k == n - 1) enable = 1'b0;
            accept();
        end
        repeat (30) @(negedge clk);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        mode_level = 0; m_level = 0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(start_o == 1, "R1", "start_o in reset", int'(start_o), 1);
        chk(cs_no == 1 && rd_no == 1, "R1", "strobes in reset", int'({cs_no, rd_no}), 3);
        chk(sample_valid_o == 0, "R1", "valid in reset", int'(sample_valid_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(start_o == 1, "R1", "start_o after reset", int'(start_o), 1);
        chk(timeout_o == 0 && sample_valid_o == 0, "R1", "flags after reset",
            int'({timeout_o, sample_valid_o}), 0);
    endtask

    task automatic t_pulse();
        set_mode(0);
        run_convs("R2", "R4", 3);
    endtask

    task automatic t_level();
        set_mode(1);
        run_convs("R3", "R5", 3);
    endtask

    task automatic t_level_late_busy();
        // R5: status still low from last conversion; busy rises 6 cycles after start
        late_busy = 6;
        run_convs("R3", "R5", 2);
        late_busy = 0;
    endtask

    task automatic t_backpressure();
        bit got;
        logic [13:0] snap;
        int s0;
        set_mode(0);
        enable = 1'b1;
        wait_valid("R8", got);
        snap = sample_o;
        s0 = start_cnt;
        repeat (60) @(negedge clk);
        chk(sample_valid_o == 1, "R8", "valid held without ready", int'(sample_valid_o), 1);
        chk(sample_o == snap, "R8", "sample held", int'(sample_o), int'(snap));
        chk(start_cnt == s0, "R8", "starts while pending", start_cnt - s0, 0);
        enable = 1'b0;
        accept();
        @(negedge clk);
        chk(sample_valid_o == 0, "R8", "valid cleared after accept", int'(sample_valid_o), 0);
        repeat (20) @(negedge clk);
    endtask

    task automatic t_ignore_idle_pulse();
        int c0;
        bit bad;
        c0 = cs_fall_cnt;
        bad = 0;
        repeat (5) @(negedge clk);
        inj_pulse = 1;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (!cs_no || sample_valid_o) bad = 1;
        end
        chk(!bad && cs_fall_cnt == c0, "R11", "read after idle status pulse", int'(bad), 0);
    endtask

    task automatic t_timeout();
        int len;
        int waited;
        int c0;
        bit got;
        set_mode(0);
        resp_en = 0;
        c0 = cs_fall_cnt;
        enable = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            if (start_o == 0) break;
        end
        waited = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            waited++;
            if (timeout_o) break;
        end
        chk(timeout_o == 1, "R9", "timeout flag", int'(timeout_o), 1);
        chk(waited == START_EXP + TMO_EXP, "R9", "cycles to timeout", waited, START_EXP + TMO_EXP);
        chk(cs_fall_cnt == c0, "R9", "reads during timeout", cs_fall_cnt - c0, 0);
        resp_en = 1;
        repeat (2) @(negedge clk);
        chk(timeout_o == 0, "R9", "timeout cleared by next start", int'(timeout_o), 0);
        wait_valid("R9", got);
        if (got) chk(sample_o == last_result, "R9", "sample after recovery",
                     int'(sample_o), int'(last_result));
        enable = 1'b0;
        accept();
        repeat (30) @(negedge clk);
        len = 0;
    endtask

    task automatic t_mode_freeze();
        int len;
        bit bad;
        bit got;
        set_mode(1);
        enable = 1'b1;
        start_len("R10", len);
        // controller now waits for completion; flip the convention input
        mon_mute = 1;
        mode_level = 1'b0;
        enable = 1'b0;
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (start_o != 0) bad = 1;
        end
        chk(!bad, "R10", "start_o level during conversion", int'(bad), 0);
        wait_valid("R10", got);
        if (got) chk(sample_o == last_result, "R10", "sample with frozen mode",
                     int'(sample_o), int'(last_result));
        m_level = 0;
        accept();
        repeat (15) @(negedge clk);
        chk(start_o == 1, "R10", "start_o rest level after idle", int'(start_o), 1);
        repeat (40) @(negedge clk);
        mon_mute = 0;
    endtask

    initial begin
        t_reset();
        t_pulse();
        t_backpressure();
        t_ignore_idle_pulse();
        t_timeout();
        t_level();
        t_level_late_busy();
        t_mode_freeze();
        t_pulse();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule